// File: doc/BRIEF.md
# Calendar Clock Update-Cycle Controller

This block holds the current time and date in byte-wide registers and advances them once per second. A warning strobe that comes shortly before each one-second tick raises an update-in-progress flag. Software polls that flag to know when reads of the time are about to become unsafe. When the tick arrives, the block runs a fixed-length update cycle. Register writes are locked out during the cycle. In its last clock the block commits the new time in one step and drops the flag.

Each value can be kept as packed BCD or as plain binary, and hours can be kept in a 24-hour or a 12-hour form. In the 12-hour form the top bit of the hour byte marks the afternoon. Software stops the clock while it loads a new time in either of two ways: by setting a freeze bit in the mode register, or by parking the divider field in one of its two reset codes. A tick that arrives while the clock is stopped is lost, not deferred.

Top module: `cal_clock_ctrl`

## Requirements
- R1: After reset the registers read as follows: 0x00 for second, minute, hour, weekday and year; 0x01 for day and month; 0x20 for the divider/status register (address 10); and 0x02 for the mode register (address 11). `uip_o` is low. Addresses 1, 3, 5 and 12 to 15 always read 0x00.
- R2: A `warn_tick` while the clock runs raises `uip_o`, which is also bit 7 of address 10, at the next clock edge. The flag stays high until the update that follows, and the time is not changed by the warning.
- R3: A `sec_tick` while the clock runs starts an update. The time registers change exactly UPD_CYCLES clock edges after the edge that samples the tick. `uip_o` is high from that sampling edge until the commit edge and low after it.
- R4: In BCD mode (mode bit 2 = 0) seconds and minutes count 00 to 59 with a decimal digit carry, and hours count 00 to 23 when mode bit 1 = 1. Each wrap carries into the next field.
- R5: In binary mode (mode bit 2 = 1) the same fields hold plain binary values and wrap at 59, 59 and 23.
- R6: In 12-hour mode (mode bit 1 = 0) the hour byte holds 1 to 12 in its low bits and a PM flag in bit 7. The sequence is 12, 1, ..., 11. The PM flag toggles on the step from 11 to 12, and the day advances on the step from 11 PM to 12 AM.
- R7: The day of month wraps to 1 after the last day of the month: 30 days for months 4, 6, 9 and 11, and 31 days for the other months except 2. Month 2 has 29 days when the year is divisible by 4 and 28 days otherwise.
- R8: The month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0.
- R9: The weekday (address 6) advances with the day from 1 up to 7 and then wraps to 1. A weekday of 0 stays 0.
- R10: While mode bit 7 (freeze) is 1, ticks are dropped, warnings do not raise `uip_o`, and a pending `uip_o` falls one edge after the clock stops.
- R11: A divider code of 6 or 7 in bits 6:4 of address 10 stops the clock in the same way as R10. Bits 6:0 of address 10 read back as written, and a write to bit 7 has no effect.
- R12: A write in the cycle that starts an update, or in any cycle of the update, is discarded.
- R13: A tick dropped while the clock was stopped is not replayed after the clock resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| warn_tick | input | 1 | Single-cycle warning strobe that precedes the second tick |
| sec_tick | input | 1 | Single-cycle one-second strobe that starts an update |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for both reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| uip_o | output | 1 | Update-in-progress flag |

## Verification
The hardest situations to reach are the races between software and the update: a write that lands on the tick edge itself, a freeze that arrives while the flag is already raised, and a tick that falls inside a freeze and must not reappear afterwards. The directed tasks place the write strobe on the same clock as the tick and one clock after it, and raise the freeze bit between a warning and its tick. They also release the freeze and then idle for longer than one update cycle before reading the registers. Month-end and year-end cases are reached by loading times one second before each boundary.

// File: rtl/cal_clock_pkg.sv
package cal_clock_pkg;

  localparam int unsigned REG_SEC  = 0;
  localparam int unsigned REG_MIN  = 2;
  localparam int unsigned REG_HOUR = 4;
  localparam int unsigned REG_WDAY = 6;
  localparam int unsigned REG_MDAY = 7;
  localparam int unsigned REG_MON  = 8;
  localparam int unsigned REG_YEAR = 9;
  localparam int unsigned REG_DIV  = 10;
  localparam int unsigned REG_MODE = 11;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] year;
  } cal_time_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2
  } upd_state_t;

  // Stored byte to binary value, BCD when bin is 0.
  function automatic logic [6:0] to_bin(input logic [7:0] v, input logic bin);
    if (bin) return v[6:0];
    return 7'(v[7:4] * 10 + v[3:0]);
  endfunction

  // Binary value (0..99) to stored byte.
  function automatic logic [7:0] from_bin(input logic [6:0] b, input logic bin);
    if (bin) return {1'b0, b};
    return {4'(b / 10), 4'(b % 10)};
  endfunction

  // Hour byte to 0..23.
  function automatic logic [6:0] hour_to_24(input logic [7:0] v, input logic bin,
                                            input logic h24);
    logic [6:0] h;
    logic [6:0] base;
    if (h24) return to_bin(v, bin);
    h    = to_bin({1'b0, v[6:0]}, bin);
    base = (h == 7'd12) ? 7'd0 : h;
    return v[7] ? 7'(base + 7'd12) : base;
  endfunction

  // 0..23 to hour byte.
  function automatic logic [7:0] hour_from_24(input logic [6:0] h, input logic bin,
                                              input logic h24);
    logic       pm;
    logic [6:0] r;
    logic [7:0] enc;
    if (h24) return from_bin(h, bin);
    pm  = (h >= 7'd12);
    r   = pm ? 7'(h - 7'd12) : h;
    if (r == 7'd0) r = 7'd12;
    enc = from_bin(r, bin);
    return {pm, enc[6:0]};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] m, input logic [6:0] y);
    case (m)
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      7'd2:                    return (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      default:                 return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_advance.sv
module cal_advance
  import cal_clock_pkg::*;
(
  input  cal_time_t cur_i,
  input  logic      bin_i,
  input  logic      h24_i,
  output cal_time_t nxt_o,
  output logic      day_carry_o
);

  logic [6:0] s, m, h, w, d, mo, y, dim;
  logic       c_s, c_m, c_h, c_d, c_mo;
  logic [6:0] ns, nm, nh, nw, nd, nmo, ny;

  always_comb begin
    s   = to_bin(cur_i.sec, bin_i);
    m   = to_bin(cur_i.min, bin_i);
    h   = hour_to_24(cur_i.hour, bin_i, h24_i);
    w   = to_bin(cur_i.wday, bin_i);
    d   = to_bin(cur_i.mday, bin_i);
    mo  = to_bin(cur_i.mon, bin_i);
    y   = to_bin(cur_i.year, bin_i);
    dim = month_len(mo, y);

    c_s  = (s >= 7'd59);
    c_m  = c_s && (m >= 7'd59);
    c_h  = c_m && (h >= 7'd23);
    c_d  = c_h && (d >= dim);
    c_mo = c_d && (mo >= 7'd12);

    ns  = c_s  ? 7'd0 : 7'(s + 7'd1);
    nm  = c_m  ? 7'd0 : 7'(m + 7'd1);
    nh  = c_h  ? 7'd0 : 7'(h + 7'd1);
    nw  = (w >= 7'd7) ? 7'd1 : 7'(w + 7'd1);
    nd  = c_d  ? 7'd1 : 7'(d + 7'd1);
    nmo = c_mo ? 7'd1 : 7'(mo + 7'd1);
    ny  = (y >= 7'd99) ? 7'd0 : 7'(y + 7'd1);

    nxt_o      = cur_i;
    nxt_o.sec  = from_bin(ns, bin_i);
    if (c_s) nxt_o.min  = from_bin(nm, bin_i);
    if (c_m) nxt_o.hour = hour_from_24(nh, bin_i, h24_i);
    if (c_h) begin
      nxt_o.mday = from_bin(nd, bin_i);
      if (w != 7'd0) nxt_o.wday = from_bin(nw, bin_i);
    end
    if (c_d)  nxt_o.mon  = from_bin(nmo, bin_i);
    if (c_mo) nxt_o.year = from_bin(ny, bin_i);
    day_carry_o = c_h;
  end

endmodule

// File: rtl/cal_upd_seq.sv
module cal_upd_seq
  import cal_clock_pkg::*;
#(
  parameter int unsigned UPD_CYCLES = 4
)(
  input  logic clk,
  input  logic rst_n,
  input  logic warn_i,
  input  logic tick_i,
  input  logic inhibit_i,
  output logic uip_o,
  output logic upd_start_o,
  output logic upd_active_o,
  output logic upd_commit_o
);

  localparam int unsigned CNT_W = (UPD_CYCLES > 1) ? $clog2(UPD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UPD_CYCLES - 1);

  upd_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             uip_q;

  assign upd_start_o  = (state_q != ST_RUN) && tick_i && !inhibit_i;
  assign upd_active_o = (state_q == ST_RUN);
  assign upd_commit_o = (state_q == ST_RUN) && (cnt_q == '0);
  assign uip_o        = uip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      uip_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (upd_start_o) begin
            state_q <= ST_RUN;
            cnt_q   <= CNT_LAST;
            uip_q   <= 1'b1;
          end else if (warn_i && !inhibit_i) begin
            state_q <= ST_LEAD;
            uip_q   <= 1'b1;
          end
        end
        ST_LEAD: begin
          if (inhibit_i) begin
            state_q <= ST_IDLE;
            uip_q   <= 1'b0;
          end else if (upd_start_o) begin
            state_q <= ST_RUN;
            cnt_q   <= CNT_LAST;
          end
        end
        ST_RUN: begin
          if (cnt_q == '0) begin
            state_q <= ST_IDLE;
            uip_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          uip_q   <= 1'b0;
        end
      endcase
    end
  end

  // R2: the flag only rises in answer to a strobe
  p_flag_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip_q) |-> $past(warn_i || tick_i));

  // R10: a stopped, idle clock never raises the flag
  p_stopped_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && inhibit_i) |=> !uip_q);

  // R3: the run counter stays inside its window
  p_count_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_active_o |-> (cnt_q <= CNT_LAST));

endmodule

// File: rtl/cal_clock_ctrl.sv
module cal_clock_ctrl
  import cal_clock_pkg::*;
#(
  parameter int unsigned UPD_CYCLES = 4,
  parameter int unsigned ADDR_W     = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warn_tick,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              uip_o
);

  cal_time_t  time_q;
  cal_time_t  time_nxt;
  logic [2:0] div_q;
  logic [3:0] rate_q;
  logic [7:0] mode_q;

  logic inhibit;
  logic upd_start, upd_active, upd_commit;
  logic write_ok;
  logic day_carry;

  // Freeze bit, or divider parked in reset code 6 or 7
  assign inhibit  = mode_q[7] || (div_q[2:1] == 2'b11);
  assign write_ok = wr_en && !upd_active && !upd_start;

  cal_upd_seq #(.UPD_CYCLES(UPD_CYCLES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .warn_i       (warn_tick),
    .tick_i       (sec_tick),
    .inhibit_i    (inhibit),
    .uip_o        (uip_o),
    .upd_start_o  (upd_start),
    .upd_active_o (upd_active),
    .upd_commit_o (upd_commit)
  );

  cal_advance u_adv (
    .cur_i       (time_q),
    .bin_i       (mode_q[2]),
    .h24_i       (mode_q[1]),
    .nxt_o       (time_nxt),
    .day_carry_o (day_carry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h00,
                  mday: 8'h01, mon: 8'h01, year: 8'h00};
      div_q  <= 3'b010;
      rate_q <= 4'h0;
      mode_q <= 8'h02;
    end else if (upd_commit) begin
      time_q <= time_nxt;
    end else if (write_ok) begin
      case (addr)
        ADDR_W'(REG_SEC):  time_q.sec  <= wr_data;
        ADDR_W'(REG_MIN):  time_q.min  <= wr_data;
        ADDR_W'(REG_HOUR): time_q.hour <= wr_data;
        ADDR_W'(REG_WDAY): time_q.wday <= wr_data;
        ADDR_W'(REG_MDAY): time_q.mday <= wr_data;
        ADDR_W'(REG_MON):  time_q.mon  <= wr_data;
        ADDR_W'(REG_YEAR): time_q.year <= wr_data;
        ADDR_W'(REG_DIV): begin
          div_q  <= wr_data[6:4];
          rate_q <= wr_data[3:0];
        end
        ADDR_W'(REG_MODE): mode_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(REG_SEC):  rd_data = time_q.sec;
      ADDR_W'(REG_MIN):  rd_data = time_q.min;
      ADDR_W'(REG_HOUR): rd_data = time_q.hour;
      ADDR_W'(REG_WDAY): rd_data = time_q.wday;
      ADDR_W'(REG_MDAY): rd_data = time_q.mday;
      ADDR_W'(REG_MON):  rd_data = time_q.mon;
      ADDR_W'(REG_YEAR): rd_data = time_q.year;
      ADDR_W'(REG_DIV):  rd_data = {uip_o, div_q, rate_q};
      ADDR_W'(REG_MODE): rd_data = mode_q;
      default:           rd_data = 8'h00;
    endcase
  end

  // R3: the time is committed only under a raised flag
  p_commit_flagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_commit |-> uip_o);

  // R3: the flag is gone after the commit edge
  p_commit_clears_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_commit |=> !uip_o);

  // R12: no write disturbs the time inside an update
  p_hold_in_update_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_active && !upd_commit) |=> $stable(time_q));

  // R10 / R11: a stopped clock never commits
  p_stopped_no_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> !upd_commit);

  // R9: a zero weekday survives a day carry
  p_zero_wday_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_commit && day_carry && time_q.wday == 8'h00) |=> (time_q.wday == 8'h00));

endmodule

// File: tb/cal_clock_ctrl_test.sv
module cal_clock_ctrl_test;

  localparam int unsigned UPD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       warn_tick = 1'b0;
  logic       sec_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       uip_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cal_clock_ctrl #(.UPD_CYCLES(UPD), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .warn_tick(warn_tick), .sec_tick(sec_tick),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .uip_o(uip_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired got=%0d exp=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rdchk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                      input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                      input logic [7:0] y);
    wr(4'd0, s); wr(4'd2, m); wr(4'd4, h); wr(4'd6, w);
    wr(4'd7, d); wr(4'd8, mo); wr(4'd9, y);
  endtask

  // Pulse the tick, then wait until just after the commit edge
  task automatic tick_wait();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (UPD) @(negedge clk);
  endtask

  task automatic warn_pulse();
    @(negedge clk); warn_tick = 1'b1;
    @(negedge clk); warn_tick = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rdchk(4'd0, 8'h00, "R1 sec");   rdchk(4'd2, 8'h00, "R1 min");
    rdchk(4'd4, 8'h00, "R1 hour");  rdchk(4'd6, 8'h00, "R1 wday");
    rdchk(4'd7, 8'h01, "R1 mday");  rdchk(4'd8, 8'h01, "R1 mon");
    rdchk(4'd9, 8'h00, "R1 year");  rdchk(4'd10, 8'h20, "R1 div");
    rdchk(4'd11, 8'h02, "R1 mode"); rdchk(4'd1, 8'h00, "R1 gap");
    rdchk(4'd13, 8'h00, "R1 high");
    chk("R1 uip", {7'd0, uip_o}, 8'h00);
  endtask

  task automatic t_warn_and_timing();
    load(8'h09, 8'h14, 8'h10, 8'h02, 8'h05, 8'h05, 8'h20);
    warn_pulse();
    chk("R2 uip after warn", {7'd0, uip_o}, 8'h01);
    rdchk(4'd10, 8'hA0, "R2 status bit");
    repeat (3) @(negedge clk);
    rdchk(4'd0, 8'h09, "R2 time untouched");
    chk("R2 uip held", {7'd0, uip_o}, 8'h01);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (UPD - 1) @(negedge clk);
    rdchk(4'd0, 8'h09, "R3 before commit");
    chk("R3 uip before commit", {7'd0, uip_o}, 8'h01);
    @(negedge clk);
    rdchk(4'd0, 8'h10, "R4 bcd digit carry");
    rdchk(4'd2, 8'h14, "R4 min unchanged");
    chk("R3 uip after commit", {7'd0, uip_o}, 8'h00);
  endtask

  task automatic t_bcd_rollover();
    load(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick_wait();
    rdchk(4'd0, 8'h00, "R4 sec wrap");  rdchk(4'd2, 8'h00, "R4 min wrap");
    rdchk(4'd4, 8'h00, "R4 hour wrap"); rdchk(4'd6, 8'h01, "R9 wday 7 to 1");
    rdchk(4'd7, 8'h01, "R7 day 31 wrap"); rdchk(4'd8, 8'h01, "R8 month wrap");
    rdchk(4'd9, 8'h00, "R8 year wrap");
    load(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h10);
    tick_wait();
    rdchk(4'd7, 8'h01, "R7 april 30 wrap"); rdchk(4'd8, 8'h05, "R7 april to may");
    rdchk(4'd6, 8'h04, "R9 wday step");
  endtask

  task automatic t_binary();
    wr(4'd11, 8'h06);
    load(8'h3B, 8'h3B, 8'h17, 8'h00, 8'h1C, 8'h02, 8'h17);
    tick_wait();
    rdchk(4'd0, 8'h00, "R5 bin sec wrap"); rdchk(4'd4, 8'h00, "R5 bin hour wrap");
    rdchk(4'd7, 8'h01, "R7 feb 28 common"); rdchk(4'd8, 8'h03, "R7 to march");
    rdchk(4'd6, 8'h00, "R9 zero wday kept");
    load(8'h3B, 8'h3B, 8'h17, 8'h00, 8'h1C, 8'h02, 8'h18);
    tick_wait();
    rdchk(4'd7, 8'h1D, "R7 feb 29 leap");
    wr(4'd0, 8'h3B); wr(4'd2, 8'h3B); wr(4'd4, 8'h17);
    tick_wait();
    rdchk(4'd7, 8'h01, "R7 leap wrap"); rdchk(4'd8, 8'h03, "R7 leap march");
    load(8'h1D, 8'h05, 8'h05, 8'h01, 8'h01, 8'h01, 8'h01);
    tick_wait();
    rdchk(4'd0, 8'h1E, "R5 bin plain step");
  endtask

  task automatic t_twelve_hour();
    wr(4'd11, 8'h00);
    load(8'h59, 8'h59, 8'h11, 8'h03, 8'h15, 8'h06, 8'h24);
    tick_wait();
    rdchk(4'd4, 8'h92, "R6 11am to 12pm"); rdchk(4'd7, 8'h15, "R6 no day carry");
    wr(4'd0, 8'h59); wr(4'd2, 8'h59); wr(4'd4, 8'h92);
    tick_wait();
    rdchk(4'd4, 8'h81, "R6 12pm to 1pm");
    wr(4'd0, 8'h59); wr(4'd2, 8'h59); wr(4'd4, 8'h91);
    tick_wait();
    rdchk(4'd4, 8'h12, "R6 11pm to 12am"); rdchk(4'd7, 8'h16, "R6 day carry");
    rdchk(4'd6, 8'h04, "R9 wday with 12h");
    wr(4'd0, 8'h59); wr(4'd2, 8'h59);
    tick_wait();
    rdchk(4'd4, 8'h01, "R6 12am to 1am");
    wr(4'd11, 8'h02);
  endtask

  task automatic t_freeze();
    load(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    warn_pulse();
    wr(4'd11, 8'h82);
    @(negedge clk);
    chk("R10 pending uip drops", {7'd0, uip_o}, 8'h00);
    warn_pulse();
    chk("R10 warn ignored", {7'd0, uip_o}, 8'h00);
    tick_wait();
    rdchk(4'd0, 8'h20, "R10 tick dropped");
    wr(4'd11, 8'h02);
    repeat (UPD + 3) @(negedge clk);
    rdchk(4'd0, 8'h20, "R13 no replay");
    chk("R13 uip idle", {7'd0, uip_o}, 8'h00);
    tick_wait();
    rdchk(4'd0, 8'h21, "R10 resumes");
  endtask

  task automatic t_divider();
    wr(4'd10, 8'hE5);
    rdchk(4'd10, 8'h65, "R11 bit7 read-only");
    warn_pulse();
    chk("R11 code6 no flag", {7'd0, uip_o}, 8'h00);
    tick_wait();
    rdchk(4'd0, 8'h21, "R11 code6 stops");
    wr(4'd10, 8'h70);
    tick_wait();
    rdchk(4'd0, 8'h21, "R11 code7 stops");
    wr(4'd10, 8'h26);
    rdchk(4'd10, 8'h26, "R11 readback");
    tick_wait();
    rdchk(4'd0, 8'h22, "R11 runs again");
  endtask

  task automatic t_write_block();
    @(negedge clk);
    sec_tick = 1'b1; addr = 4'd0; wr_data = 8'h45; wr_en = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0; wr_data = 8'h46;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (UPD - 1) @(negedge clk);
    rdchk(4'd0, 8'h23, "R12 writes discarded");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_warn_and_timing();
    t_bcd_rollover();
    t_binary();
    t_twelve_hour();
    t_freeze();
    t_divider();
    t_write_block();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule